// File: doc/BRIEF.md
# Video Line-Fetch DMA with Pixel FIFO

This block keeps a 32-bit display FIFO supplied from frame memory. It issues fixed 16-byte burst read requests on a simple request/acknowledge interface and collects the four returned words of each burst into a 24-entry FIFO. The display side drains the FIFO through a read strobe with the data shown ahead of the strobe. A burst is only requested when the whole burst is sure to fit, and only one burst is in flight at any time.

Two scan orders are supported. In progressive order every line of the frame is fetched in sequence from buffer A. In interlaced order the odd lines are fetched first from buffer A, where they lie back to back, and then the even lines from buffer B. After the last burst of a frame, fetching starts again at the buffer A base. The display-ready output stays low after enable until five complete bursts have landed. This gives the display a primed FIFO before it starts pulling. A read of an empty FIFO is reported with a one-cycle underrun pulse.

Top module: `vid_line_fetch`

## Requirements
- R1: The FIFO holds up to 24 words of 32 bits, never holds more, and returns the words on `pix_data` in the order they arrived.
- R2: `req` is high exactly when `en` is high, no burst is outstanding and at least 4 FIFO entries are free. While high and not acknowledged it stays high with an unchanged `req_addr`.
- R3: `req_addr` always has bits [3:0] equal to zero. The low four bits of both base inputs are ignored.
- R4: After enable, `pix_ready` stays low until the fourth word of the fifth burst has been written. It rises on the clock edge that writes that word and then stays high while `en` stays high.
- R5: In progressive mode (`interlace`=0), burst k of a frame reads `base_a + 16*k` for k from 0 to `line_bursts*line_count-1`, then the frame repeats from k=0.
- R6: In interlaced mode (`interlace`=1), the first `ceil(line_count/2)*line_bursts` bursts read buffer A sequentially. The next `floor(line_count/2)*line_bursts` bursts read buffer B sequentially from `base_b`. Buffer B is skipped when `line_count`=1, and the frame then repeats.
- R7: A burst is accepted when `req` and `req_ack` are high on the same edge. It then owns the next 4 `rd_valid` words. `rd_valid` while no burst is outstanding is ignored and leaves the FIFO untouched.
- R8: A `pix_rd` while enabled and the FIFO is empty raises `underrun` for the following cycle and leaves the FIFO unchanged. A `pix_rd` of a non-empty FIFO raises no pulse.
- R9: While `en` is low, the FIFO is emptied, `pix_ready` is cleared, any outstanding burst is dropped and the frame position returns to the start of buffer A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low holds the block idle and rewinds it |
| interlace | input | 1 | 1 = odd lines from A then even lines from B; 0 = progressive from A |
| base_a | input | 32 | Buffer A base byte address (bits [3:0] ignored) |
| base_b | input | 32 | Buffer B base byte address (bits [3:0] ignored) |
| line_bursts | input | 10 | Bursts per line, at least 1 |
| line_count | input | 11 | Lines per frame, at least 1 |
| req | output | 1 | Burst read request |
| req_addr | output | 32 | Burst byte address, 16-byte aligned |
| req_ack | input | 1 | Memory accepts the request on this edge |
| rd_valid | input | 1 | Returned data word valid |
| rd_data | input | 32 | Returned data word |
| pix_rd | input | 1 | Display pops the FIFO head |
| pix_data | output | 32 | FIFO head word |
| pix_ready | output | 1 | FIFO primed with five bursts since enable |
| underrun | output | 1 | One-cycle pulse after a read of an empty FIFO |

## Verification
The bench aims at the priming edge. A design that counted words instead of bursts, or registered readiness one cycle late, would raise `pix_ready` at the wrong cycle. It also runs a FIFO that fills with no reader: an off-by-one in the free-space test would request a burst into 21 or more held words and overflow, or stall at 20. It covers interlaced frames with odd line counts and a single line, where a wrong half-count or a missing skip of buffer B shows up as a wrong burst address. It also sends stray return words while nothing is outstanding and reads from an empty FIFO. A design that accepted the stray words would corrupt the data order, and one that popped on an empty read would miss the underrun pulse.

// File: rtl/vid_line_fetch.sv
module vid_line_fetch #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int DEPTH  = 24,
  parameter int BEATS  = 4,
  parameter int PRIME  = 5,
  parameter int LW     = 10,
  parameter int NW     = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          interlace,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  input  logic [LW-1:0] line_bursts,
  input  logic [NW-1:0] line_count,
  output logic          req,
  output logic [AW-1:0] req_addr,
  input  logic          req_ack,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  input  logic          pix_rd,
  output logic [DW-1:0] pix_data,
  output logic          pix_ready,
  output logic          underrun
);
  localparam int PW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int LCW   = $clog2(PRIME + 1);
  localparam int BYTES = BEATS * DW / 8;
  localparam int OFS   = $clog2(BYTES);

  logic [DW-1:0]  mem [DEPTH];
  logic [PW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;
  logic           busy;
  logic [BW-1:0]  beat;
  logic [LCW-1:0] landed;
  logic [AW-1:0]  addr;
  logic [LW-1:0]  bidx;
  logic [NW-1:0]  lidx;
  logic           field;
  logic [NW-1:0]  field_lines;

  wire accept     = req && req_ack;
  wire wr         = busy && rd_valid;
  wire rd         = pix_rd && (cnt != '0);
  wire last_beat  = (beat == BW'(BEATS - 1));
  wire last_burst = (bidx == line_bursts - LW'(1));
  wire last_line  = (lidx == field_lines - NW'(1));
  wire has_even   = (line_count >> 1) != '0;

  always_comb begin
    if (!interlace)  field_lines = line_count;
    else if (field)  field_lines = line_count >> 1;
    else             field_lines = NW'(({1'b0, line_count} + 1'b1) >> 1);
  end

  assign req      = en && !busy && ((CW'(DEPTH) - cnt) >= CW'(BEATS));
  assign req_addr = {addr[AW-1:OFS], {OFS{1'b0}}};
  assign pix_data = mem[rp];

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      busy <= 1'b0; beat <= '0; landed <= '0;
      pix_ready <= 1'b0; underrun <= 1'b0;
      addr <= '0; bidx <= '0; lidx <= '0; field <= 1'b0;
    end else if (!en) begin
      wp <= '0; rp <= '0; cnt <= '0;
      busy <= 1'b0; beat <= '0; landed <= '0;
      pix_ready <= 1'b0; underrun <= 1'b0;
      addr <= base_a; bidx <= '0; lidx <= '0; field <= 1'b0;
    end else begin
      underrun <= pix_rd && (cnt == '0);
      if (wr) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (rd) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      cnt <= cnt + CW'(wr) - CW'(rd);

      if (accept) begin
        busy <= 1'b1;
        beat <= '0;
        if (!last_burst) begin
          bidx <= bidx + LW'(1);
          addr <= addr + AW'(BYTES);
        end else begin
          bidx <= '0;
          if (!last_line) begin
            lidx <= lidx + NW'(1);
            addr <= addr + AW'(BYTES);
          end else begin
            lidx <= '0;
            if (interlace && !field && has_even) begin
              field <= 1'b1;
              addr  <= base_b;
            end else begin
              field <= 1'b0;
              addr  <= base_a;
            end
          end
        end
      end else if (wr) begin
        beat <= beat + BW'(1);
        if (last_beat) begin
          busy <= 1'b0;
          if (landed != LCW'(PRIME)) landed <= landed + LCW'(1);
          if (landed == LCW'(PRIME - 1)) pix_ready <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vid_line_fetch_chk.sv
module vid_line_fetch_chk #(
  parameter int AW    = 32,
  parameter int CW    = 5,
  parameter int DEPTH = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          req,
  input logic          req_ack,
  input logic [AW-1:0] req_addr,
  input logic          pix_rd,
  input logic          pix_ready,
  input logic          underrun,
  input logic [CW-1:0] cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R1
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !req_ack) |=> (!en || (req && $stable(req_addr)))); // R2
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_ack) |=> !req); // R7
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && en) |=> (pix_ready || !en)); // R4
  AST_READY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pix_ready); // R9
  AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> ($past(pix_rd) && $past(en) && $past(cnt) == '0)); // R8
endmodule

bind vid_line_fetch vid_line_fetch_chk #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .req(req), .req_ack(req_ack),
  .req_addr(req_addr), .pix_rd(pix_rd), .pix_ready(pix_ready),
  .underrun(underrun), .cnt(cnt)
);

// File: tb/sim_vid_line_fetch.sv
`timescale 1ns/1ps
module sim_vid_line_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, interlace = 1'b0;
  logic [31:0] base_a = '0, base_b = '0;
  logic [9:0]  line_bursts = 10'd1;
  logic [10:0] line_count = 11'd1;
  logic        req, req_ack = 1'b0, rd_valid = 1'b0, pix_rd = 1'b0;
  logic [31:0] req_addr, rd_data = '0, pix_data;
  logic        pix_ready, underrun;

  always #2 clk = ~clk;

  vid_line_fetch u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .interlace(interlace),
    .base_a(base_a), .base_b(base_b), .line_bursts(line_bursts),
    .line_count(line_count), .req(req), .req_addr(req_addr),
    .req_ack(req_ack), .rd_valid(rd_valid), .rd_data(rd_data),
    .pix_rd(pix_rd), .pix_data(pix_data), .pix_ready(pix_ready),
    .underrun(underrun)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic        c_en = 0, c_il = 0;
  logic [31:0] c_a = 0, c_b = 0;
  int          c_lb = 1, c_n = 1, rd_pct = 0;

  logic [31:0] q[$];
  int  left = 0, landed = 0, k = 0;
  bit  outst = 0, rdy_exp = 0, und_exp = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input int kk);
    logic [31:0] al, bl;
    int na;
    al = c_a & ~32'hF;
    bl = c_b & ~32'hF;
    na = ((c_n + 1) / 2) * c_lb;
    if (!c_il || kk < na) return al + 32'(kk * 16);
    return bl + 32'((kk - na) * 16);
  endfunction

  task automatic step();
    bit req_exp;
    @(negedge clk);
    req_exp = en && !outst && (24 - q.size() >= 4);
    chk(req === req_exp, "R2 req", 32'(req), 32'(req_exp));
    chk(pix_ready === rdy_exp, "R4 R9 pix_ready", 32'(pix_ready), 32'(rdy_exp));
    chk(underrun === und_exp, "R8 underrun", 32'(underrun), 32'(und_exp));
    en = c_en; interlace = c_il; base_a = c_a; base_b = c_b;
    line_bursts = 10'(c_lb); line_count = 11'(c_n);
    req_ack = req && ($urandom % 3 != 0);
    rd_valid = outst ? ($urandom % 4 != 0) : ($urandom % 5 == 0);
    rd_data = $urandom;
    pix_rd = ($urandom % 100) < rd_pct;
    #1;
    if (!en) begin
      q.delete(); outst = 0; left = 0; landed = 0; rdy_exp = 0; k = 0; und_exp = 0;
    end else begin
      und_exp = pix_rd && q.size() == 0;
      if (pix_rd && q.size() > 0) begin
        chk(pix_data === q[0], "R1 R7 data order", pix_data, q[0]);
        void'(q.pop_front());
      end
      if (rd_valid && outst) begin
        q.push_back(rd_data);
        left--;
        if (left == 0) begin
          outst = 0;
          landed++;
          if (landed >= 5) rdy_exp = 1;
        end
      end
      if (req && req_ack) begin
        if (c_il) chk(req_addr === exp_addr(k), "R3 R6 burst address", req_addr, exp_addr(k));
        else      chk(req_addr === exp_addr(k), "R3 R5 burst address", req_addr, exp_addr(k));
        k = (k + 1) % (c_n * c_lb);
        outst = 1;
        left = 4;
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic start();
    c_en = 1;
    run(1);
    @(posedge clk); #1;
    chk(req === 1'b1, "R9 req after enable", 32'(req), 32'd1);
    chk(req_addr === (c_a & ~32'hF), "R9 restart at buffer A", req_addr, c_a & ~32'hF);
    chk(pix_ready === 1'b0, "R4 not ready at enable", 32'(pix_ready), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(req === 1'b0, "reset req", 32'(req), 32'd0);
    chk(pix_ready === 1'b0, "reset pix_ready", 32'(pix_ready), 32'd0);
    chk(underrun === 1'b0, "reset underrun", 32'(underrun), 32'd0);
    rst_n = 1'b1;
    run(4);

    c_il = 0; c_a = 32'h0001_0007; c_b = 32'h0009_0000; c_lb = 2; c_n = 3; rd_pct = 0;
    run(2);
    start();
    run(300);
    chk(q.size() == 24, "R1 R2 fill stops at capacity", 32'(q.size()), 32'd24);
    rd_pct = 40;
    run(1500);

    c_en = 0; run(4);
    c_il = 1; c_a = 32'h0000_2000; c_b = 32'h0000_8008; c_lb = 1; c_n = 5; rd_pct = 35;
    run(2);
    start();
    run(2000);

    c_en = 0; run(4);
    c_il = 1; c_a = 32'h0004_000C; c_b = 32'h0007_0000; c_lb = 3; c_n = 1; rd_pct = 30;
    run(2);
    start();
    run(1500);

    c_en = 0; run(4);
    c_il = 0; c_a = 32'h0000_0100; c_lb = 4; c_n = 2; rd_pct = 100;
    run(2);
    start();
    run(300);
    rd_pct = 60;
    run(1500);

    c_en = 0; run(4);
    c_il = 1; c_a = 32'h0010_0000; c_b = 32'h0020_0000; c_lb = 2; c_n = 4; rd_pct = 45;
    run(2);
    start();
    run(2500);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule